// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupts

This block controls a single general-purpose I/O port of up to eight pins through a small synchronous register interface. Every pin owns a 32-byte register window. The window holds the pin's setup word, a debounce threshold, a read-only view of the filtered pad level, a float control, the level to drive, and an acknowledge register for the pin's interrupt. A port-wide status word reports which pins hold a pending interrupt. The block has one interrupt output.

Each pad input passes through a two-stage synchroniser and then an optional stability filter. An edge/level detector watches the filtered value. Edge events latch a sticky pending flag that stays set until software acknowledges it. A level trigger re-asserts the flag on every cycle in which the level is active. Output drive is a tri-state pair: `pad_oe` and `pad_out`.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zero, `irq` is 0 and the status word at byte address 0x104 reads 0.
- R2: Pin n's window starts at byte address n*0x20. At offset 0x00 the setup word reads back bits 0 (pin enable), 1 (drive direction), 3:2 (trigger kind), 4 (polarity) and 6 (interrupt enable), and all other bits read 0. Offset 0x04 holds an 8-bit threshold in bits 7:0. Offset 0x0C holds the float bit in bit 0. Offset 0x10 holds the drive level in bit 0.
- R3: `pad_oe[n]` is 1 exactly when pin n is enabled, its direction bit is 1 and its float bit is 0. `pad_out[n]` equals bit 0 of the drive-level register.
- R4: Bit 0 at offset 0x08 reads the synchronised, filtered pad level. With threshold 0 a pad change is visible within three clocks.
- R5: With a nonzero threshold T, the filtered level takes a new pad value only after that value has been steady for T clocks. A shorter pulse never appears at offset 0x08.
- R6: Trigger kind 2 is a single edge. Polarity 1 latches pending on a rising edge only, and polarity 0 on a falling edge only.
- R7: Trigger kind 3 latches pending on both edges, whatever the polarity.
- R8: Trigger kind 1 is level-sensitive: polarity 1 means active high and polarity 0 means active low. While the level is active, pending stays 1 even right after an acknowledge.
- R9: Pending is sticky. Writing 1 to bit 0 at offset 0x14 clears it, and writing 0 there leaves it unchanged.
- R10: Bit n of the status word at 0x104 is pin n's pending flag.
- R11: `irq` is 1 exactly when some pin is pending, enabled and has its interrupt-enable bit set.
- R12: A pin with trigger kind 0, or with enable 0, never sets pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Level to drive on each pad |
| pad_oe | output | NUM_PINS | Drive enable per pad |
| irq | output | 1 | Port interrupt |

## Verification
The detector is exercised with isolated rising and falling edges under every trigger kind and both polarities. This separates single-edge from double-edge behaviour and shows that polarity is ignored in double-edge mode. Level mode is tried with an acknowledge issued while the level is still active and again after it has gone away. The two results separate the level behaviour from the sticky-edge behaviour. The filter receives a pulse shorter than its threshold and then a long hold, which separates filtering from plain synchronisation. The interrupt line is observed while the interrupt-enable bit and the pin-enable bit are toggled around a latched event.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int DATA_W = 32;

  // word index inside one pin window
  localparam logic [2:0] WIN_SETUP = 3'd0;
  localparam logic [2:0] WIN_DBNC  = 3'd1;
  localparam logic [2:0] WIN_LEVEL = 3'd2;
  localparam logic [2:0] WIN_FLOAT = 3'd3;
  localparam logic [2:0] WIN_DRIVE = 3'd4;
  localparam logic [2:0] WIN_ACK   = 3'd5;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic  irq_en;
    logic  pol;
    trig_e kind;
    logic  dir_out;
    logic  en;
  } pin_setup_t;

  function automatic pin_setup_t setup_from_word(input logic [DATA_W-1:0] w);
    pin_setup_t s;
    s.en      = w[0];
    s.dir_out = w[1];
    s.kind    = trig_e'(w[3:2]);
    s.pol     = w[4];
    s.irq_en  = w[6];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] setup_to_word(input pin_setup_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0]   = s.en;
    w[1]   = s.dir_out;
    w[3:2] = s.kind;
    w[4]   = s.pol;
    w[6]   = s.irq_en;
    return w;
  endfunction

  function automatic logic level_active(input pin_setup_t s, input logic lvl);
    return s.en && (s.kind == TRIG_LEVEL) && (lvl == s.pol);
  endfunction

  function automatic logic edge_seen(input pin_setup_t s, input logic rise,
                                     input logic fall);
    logic hit;
    case (s.kind)
      TRIG_EDGE: hit = s.pol ? rise : fall;
      TRIG_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return s.en && hit;
  endfunction

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_i,
  input  logic [CNT_W-1:0] thresh,
  output logic             sync_o,
  output logic             filt_o
);
  logic             meta_q, sync_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      if (sync_q == filt_q) begin
        cnt_q <= '0;
      end else if ((thresh == '0) || (cnt_next >= {1'b0, thresh})) begin
        filt_q <= sync_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_next[CNT_W-1:0];
      end
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_trig_unit.sv
module gpio_trig_unit
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pin_setup_t setup,
  input  logic       lvl,
  input  logic       ack,
  output logic       pend_o,
  output logic       lvl_hit_o,
  output logic       edge_hit_o
);
  logic prev_q, pend_q;
  logic rise, fall;

  assign rise       = lvl & ~prev_q;
  assign fall       = ~lvl & prev_q;
  assign edge_hit_o = edge_seen(setup, rise, fall);
  assign lvl_hit_o  = level_active(setup, lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= (pend_q & ~ack) | edge_hit_o | lvl_hit_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 9,
  parameter int DBNC_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int WIN_LSB = 5;
  localparam int PIN_W   = 3;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(9'h104);

  logic               in_windows;
  logic [PIN_W-1:0]   pin_sel;
  logic [2:0]         word_sel;

  assign in_windows = (bus_addr[ADDR_W-1:WIN_LSB+PIN_W] == '0);
  assign pin_sel    = bus_addr[WIN_LSB+PIN_W-1:WIN_LSB];
  assign word_sel   = bus_addr[WIN_LSB-1:2];

  pin_setup_t        setup_q [NUM_PINS];
  logic [DBNC_W-1:0] dbnc_q  [NUM_PINS];
  logic              float_q [NUM_PINS];
  logic              drive_q [NUM_PINS];

  // named per-pin events for the checker
  logic [NUM_PINS-1:0] pend_vec, en_vec, ie_vec, trig_nz_vec;
  logic [NUM_PINS-1:0] filt_vec, sync_vec, lvl_hit_vec, edge_hit_vec, ack_vec;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    assign hit = bus_we && in_windows && (pin_sel == PIN_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        setup_q[i] <= '0;
        dbnc_q[i]  <= '0;
        float_q[i] <= 1'b0;
        drive_q[i] <= 1'b0;
      end else if (hit) begin
        case (word_sel)
          WIN_SETUP: setup_q[i] <= setup_from_word(bus_wdata);
          WIN_DBNC:  dbnc_q[i]  <= bus_wdata[DBNC_W-1:0];
          WIN_FLOAT: float_q[i] <= bus_wdata[0];
          WIN_DRIVE: drive_q[i] <= bus_wdata[0];
          default: ;
        endcase
      end
    end

    assign ack_vec[i] = hit && (word_sel == WIN_ACK) && bus_wdata[0];

    gpio_in_filter #(.CNT_W(DBNC_W)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_i  (pad_in[i]),
      .thresh (dbnc_q[i]),
      .sync_o (sync_vec[i]),
      .filt_o (filt_vec[i])
    );

    gpio_trig_unit u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup      (setup_q[i]),
      .lvl        (filt_vec[i]),
      .ack        (ack_vec[i]),
      .pend_o     (pend_vec[i]),
      .lvl_hit_o  (lvl_hit_vec[i]),
      .edge_hit_o (edge_hit_vec[i])
    );

    assign en_vec[i]      = setup_q[i].en;
    assign ie_vec[i]      = setup_q[i].irq_en;
    assign trig_nz_vec[i] = (setup_q[i].kind != TRIG_OFF);
    assign pad_oe[i]      = setup_q[i].en & setup_q[i].dir_out & ~float_q[i];
    assign pad_out[i]     = drive_q[i];
  end

  assign irq = |(pend_vec & ie_vec & en_vec);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STATUS_ADDR) begin
      bus_rdata[NUM_PINS-1:0] = pend_vec;
    end else if (in_windows) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (pin_sel == PIN_W'(p)) begin
          case (word_sel)
            WIN_SETUP: bus_rdata = setup_to_word(setup_q[p]);
            WIN_DBNC:  bus_rdata[DBNC_W-1:0] = dbnc_q[p];
            WIN_LEVEL: bus_rdata[0] = filt_vec[p];
            WIN_FLOAT: bus_rdata[0] = float_q[p];
            WIN_DRIVE: bus_rdata[0] = drive_q[p];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] en_vec,
  input logic [NUM_PINS-1:0] trig_nz_vec,
  input logic [NUM_PINS-1:0] filt_vec,
  input logic [NUM_PINS-1:0] sync_vec,
  input logic [NUM_PINS-1:0] lvl_hit_vec,
  input logic [NUM_PINS-1:0] ack_vec
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_vec & en_vec) != '0)); // R11

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec[i] && !ack_vec[i]) |=> pend_vec[i]); // R9

    AST_FILT_TAKES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_vec[i]) |-> (filt_vec[i] == $past(sync_vec[i]))); // R5

    AST_PEND_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[i]) |-> ($past(en_vec[i]) && $past(trig_nz_vec[i]))); // R12

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_hit_vec[i] |=> pend_vec[i]); // R8
  end
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (irq),
  .pend_vec    (pend_vec),
  .en_vec      (en_vec),
  .trig_nz_vec (trig_nz_vec),
  .filt_vec    (filt_vec),
  .sync_vec    (sync_vec),
  .lvl_hit_vec (lvl_hit_vec),
  .ack_vec     (ack_vec)
);

// File: tb/gpio_port_ctl_bench.sv
module gpio_port_ctl_bench;
  localparam int NP = 8;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 pad_oe, 3 pad_out
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  gpio_port_ctl #(.NUM_PINS(NP), .ADDR_W(AW), .DBNC_W(8)) u_gpio_port_ctl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = exp_q.pop_front();
      case (it.kind)
        0: got = bus_rdata;
        1: got = {31'b0, irq};
        2: got = {24'b0, pad_oe};
        default: got = {24'b0, pad_out};
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, got, it.exp);
      end
    end
  end

  function automatic logic [AW-1:0] pa(input int pin, input int ofs);
    return AW'(pin * 32 + ofs);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [AW-1:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pad(input int pin, input logic v);
    @(posedge clk); #1;
    pad_in[pin] = v;
  endtask

  localparam logic [AW-1:0] STAT = AW'(9'h104);

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    waitc(3); #1; rst_n = 1'b1;

    // R1 reset state
    rd(pa(0, 0), 32'h0, "R1 setup word after reset");
    rd(STAT, 32'h0, "R1 status after reset");
    expect_item(1, STAT, 32'h0, "R1 irq after reset");
    expect_item(2, STAT, 32'h0, "R1 pad_oe after reset");

    // R2 register map and readback masks
    wr(pa(3, 'h00), 32'hFF);
    rd(pa(3, 'h00), 32'h5F, "R2 setup readback");
    wr(pa(3, 'h04), 32'h1AB);
    rd(pa(3, 'h04), 32'hAB, "R2 threshold readback");
    wr(pa(3, 'h0C), 32'h3);
    rd(pa(3, 'h0C), 32'h1, "R2 float readback");
    wr(pa(3, 'h10), 32'h1);
    rd(pa(3, 'h10), 32'h1, "R2 drive readback");
    rd(pa(2, 'h00), 32'h0, "R2 neighbour window untouched");
    wr(pa(3, 'h00), 32'h0); wr(pa(3, 'h04), 32'h0);
    wr(pa(3, 'h0C), 32'h0); wr(pa(3, 'h10), 32'h0);

    // R3 drive control
    wr(pa(1, 'h00), 32'h3);
    wr(pa(1, 'h10), 32'h1);
    expect_item(2, STAT, 32'h02, "R3 oe when enabled output not floated");
    expect_item(3, STAT, 32'h02, "R3 pad_out follows drive level");
    wr(pa(1, 'h0C), 32'h1);
    expect_item(2, STAT, 32'h00, "R3 float releases pad");
    wr(pa(1, 'h0C), 32'h0);
    wr(pa(1, 'h00), 32'h1);
    expect_item(2, STAT, 32'h00, "R3 input direction releases pad");
    wr(pa(1, 'h00), 32'h0); wr(pa(1, 'h10), 32'h0);

    // R4 input path
    wr(pa(2, 'h00), 32'h1);
    pad(2, 1'b1); waitc(4);
    rd(pa(2, 'h08), 32'h1, "R4 input reads high");
    pad(2, 1'b0); waitc(4);
    rd(pa(2, 'h08), 32'h0, "R4 input reads low");

    // R5 debounce
    wr(pa(2, 'h04), 32'd10);
    pad(2, 1'b1); waitc(3); pad(2, 1'b0);
    for (int k = 0; k < 15; k++) rd(pa(2, 'h08), 32'h0, "R5 short pulse filtered");
    pad(2, 1'b1); waitc(20);
    rd(pa(2, 'h08), 32'h1, "R5 long hold passes");
    pad(2, 1'b0); waitc(20);
    wr(pa(2, 'h04), 32'h0); wr(pa(2, 'h00), 32'h0);

    // R6 single edge rising, with R9 sticky/ack behaviour
    wr(pa(4, 'h00), 32'h59);
    pad(4, 1'b1); waitc(6);
    rd(STAT, 32'h10, "R6 rising edge latched");
    expect_item(1, STAT, 32'h1, "R11 irq on enabled pending pin");
    wr(pa(4, 'h14), 32'h0);
    rd(STAT, 32'h10, "R9 writing 0 to ack keeps pending");
    waitc(5);
    rd(STAT, 32'h10, "R9 pending sticky over time");
    wr(pa(4, 'h14), 32'h1);
    rd(STAT, 32'h00, "R9 ack clears pending");
    pad(4, 1'b0); waitc(6);
    rd(STAT, 32'h00, "R6 falling ignored when rising selected");
    wr(pa(4, 'h00), 32'h49);
    pad(4, 1'b1); waitc(6);
    rd(STAT, 32'h00, "R6 rising ignored when falling selected");
    pad(4, 1'b0); waitc(6);
    rd(STAT, 32'h10, "R6 falling edge latched");
    wr(pa(4, 'h14), 32'h1);

    // R7 both edges, polarity 0 and 1
    wr(pa(4, 'h00), 32'h4D);
    pad(4, 1'b1); waitc(6);
    rd(STAT, 32'h10, "R7 rising with both edges");
    wr(pa(4, 'h14), 32'h1);
    pad(4, 1'b0); waitc(6);
    rd(STAT, 32'h10, "R7 falling with both edges");
    wr(pa(4, 'h14), 32'h1);
    wr(pa(4, 'h00), 32'h5D);
    pad(4, 1'b1); waitc(6);
    rd(STAT, 32'h10, "R7 polarity ignored");
    wr(pa(4, 'h14), 32'h1);
    wr(pa(4, 'h00), 32'h0);
    pad(4, 1'b0); waitc(6);

    // R8 level triggers
    wr(pa(5, 'h00), 32'h55);
    rd(STAT, 32'h00, "R8 inactive high level no pending");
    pad(5, 1'b1); waitc(6);
    rd(STAT, 32'h20, "R8 active high sets pending");
    wr(pa(5, 'h14), 32'h1);
    rd(STAT, 32'h20, "R8 pending survives ack while active");
    pad(5, 1'b0); waitc(6);
    wr(pa(5, 'h14), 32'h1);
    rd(STAT, 32'h00, "R8 ack clears once level inactive");
    wr(pa(5, 'h00), 32'h45);
    waitc(2);
    rd(STAT, 32'h20, "R8 active low sets pending");
    pad(5, 1'b1); waitc(6);
    wr(pa(5, 'h14), 32'h1);
    rd(STAT, 32'h00, "R8 active low cleared after release");
    wr(pa(5, 'h00), 32'h0);
    pad(5, 1'b0); waitc(6);

    // R10 / R11 status bits and irq gating
    wr(pa(6, 'h00), 32'h19);
    pad(6, 1'b1); waitc(6);
    rd(STAT, 32'h40, "R10 status bit 6 for pin 6");
    expect_item(1, STAT, 32'h0, "R11 no irq without interrupt enable");
    wr(pa(6, 'h00), 32'h59);
    expect_item(1, STAT, 32'h1, "R11 irq after interrupt enable");
    wr(pa(6, 'h00), 32'h58);
    expect_item(1, STAT, 32'h0, "R11 no irq with pin disabled");
    rd(STAT, 32'h40, "R10 pending kept while disabled");
    wr(pa(6, 'h14), 32'h1);
    rd(STAT, 32'h00, "R10 status clear after ack");
    wr(pa(6, 'h00), 32'h0);
    pad(6, 1'b0); waitc(6);

    // R12 no trigger kind / disabled pin
    wr(pa(7, 'h00), 32'h51);
    pad(7, 1'b1); waitc(6);
    pad(7, 1'b0); waitc(6);
    rd(STAT, 32'h00, "R12 trigger kind 0 never pends");
    wr(pa(7, 'h00), 32'h5C);
    pad(7, 1'b1); waitc(6);
    rd(STAT, 32'h00, "R12 disabled pin never pends");
    expect_item(1, STAT, 32'h0, "R12 irq quiet");

    waitc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule